// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block maps a physical byte address onto one of eight DRAM rows. Software loads one 8-bit boundary register per row. Each register holds the cumulative end of installed memory up to and including that row, counted in 8 MB granules. Row `i` therefore covers the span from the previous row's boundary (zero for row 0) up to, but not including, its own boundary. A row whose boundary does not exceed the previous one is empty and is never selected.

The decoder is combinational from the registered boundaries. It returns a one-hot row select, a hit flag, the selected row's base byte address, a per-row populated vector, and the top of memory, which is the last row's boundary. A module with two sides fills two neighbouring rows. A module with one side writes the same cumulative value into both of its rows, which leaves the second row empty. Any address at or above the top of memory misses.

Top module: `drb_decoder`

## Requirements
- R1: After reset every boundary register holds 0x01, so the populated vector reads 0x01, the top of memory reads 1 and address 0 hits row 0.
- R2: A write with `wr_en` high loads `wr_data` into boundary register `wr_row` (0 to 7) on the next rising clock edge. Without a write, no boundary changes.
- R3: `row_pop[i]` is 1 exactly when boundary `i` is greater than boundary `i-1`, with boundary `-1` taken as 0.
- R4: An address in `[prev*8MB, bnd*8MB)` of a populated row, and below the top of memory, raises `hit` and sets the matching bit in `row_sel`. `row_sel` is one-hot whenever `hit` is 1.
- R5: An empty row is never selected, even when an address equals its boundary.
- R6: An address at or above `top_mem*8MB` drives `row_sel` to 0 and `hit` to 0. This includes any address with bit 31 set.
- R7: When boundaries written out of order make several rows cover one address, the lowest-numbered row is selected.
- R8: `row_base` equals the selected row's previous boundary times 8 MB, and is 0 when `hit` is 0.
- R9: `top_mem` equals the row 7 boundary register.
- R10: The last byte below a row's boundary belongs to that row. The byte at the boundary belongs to the next populated row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Boundary register write strobe |
| wr_row | input | 3 | Index of the boundary register to write |
| wr_data | input | 8 | Cumulative boundary in 8 MB granules |
| addr | input | 32 | Physical byte address to decode |
| row_sel | output | 8 | One-hot select of the decoded row |
| hit | output | 1 | Address falls in a populated row below top of memory |
| row_base | output | 32 | Base byte address of the selected row |
| row_pop | output | 8 | Populated flag per row |
| top_mem | output | 8 | Top of memory in 8 MB granules |

## Verification
The reset layout is probed first. The decoder is then tried with an ordered layout that contains empty rows, swept over every granule and over the first and last byte of each row. This separates correct skipping of empty rows from an off-by-one at row edges. An out-of-order layout with overlapping rows shows that the lowest row wins and that an empty row is never chosen. A layout in which row 7 lies below earlier boundaries shows that the top-of-memory limit overrides a row match. A probe with bit 31 set tells a full-width compare apart from a compare on the granule bits only.

// File: rtl/drb_pkg.sv
package drb_pkg;
  localparam int unsigned DEF_ROWS     = 8;
  localparam int unsigned DEF_BND_W    = 8;
  localparam int unsigned DEF_ADDR_W   = 32;
  localparam int unsigned DEF_GRAN_LSB = 23;
  localparam logic [DEF_BND_W-1:0] DEF_BND_RST = 8'h01;
endpackage

// File: rtl/drb_regfile.sv
module drb_regfile #(
  parameter int unsigned NUM_ROWS = drb_pkg::DEF_ROWS,
  parameter int unsigned BND_W    = drb_pkg::DEF_BND_W,
  parameter logic [BND_W-1:0] RST_VAL = drb_pkg::DEF_BND_RST,
  localparam int unsigned IDX_W   = $clog2(NUM_ROWS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_row,
  input  logic [BND_W-1:0]          wr_data,
  output logic [NUM_ROWS*BND_W-1:0] bnd_flat
);
  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_reg
    logic             load;
    logic [BND_W-1:0] bnd_q;
    logic [BND_W-1:0] bnd_d;

    always_comb begin
      load  = wr_en && (wr_row == IDX_W'(i));
      bnd_d = load ? wr_data : bnd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bnd_q <= RST_VAL;
      else        bnd_q <= bnd_d;
    end

    assign bnd_flat[i*BND_W +: BND_W] = bnd_q;
  end
endmodule

// File: rtl/drb_row_cmp.sv
module drb_row_cmp #(
  parameter int unsigned BND_W    = drb_pkg::DEF_BND_W,
  parameter int unsigned ADDR_W   = drb_pkg::DEF_ADDR_W,
  parameter int unsigned GRAN_LSB = drb_pkg::DEF_GRAN_LSB,
  localparam int unsigned PAD_W   = ADDR_W - BND_W - GRAN_LSB
) (
  input  logic [BND_W-1:0]  lo_gran,
  input  logic [BND_W-1:0]  hi_gran,
  input  logic [ADDR_W-1:0] addr,
  output logic              populated,
  output logic              match
);
  logic [ADDR_W-1:0] lo_byte;
  logic [ADDR_W-1:0] hi_byte;

  always_comb begin
    lo_byte   = {{PAD_W{1'b0}}, lo_gran, {GRAN_LSB{1'b0}}};
    hi_byte   = {{PAD_W{1'b0}}, hi_gran, {GRAN_LSB{1'b0}}};
    populated = hi_gran > lo_gran;
    match     = populated && (addr >= lo_byte) && (addr < hi_byte);
  end
endmodule

// File: rtl/drb_prio_sel.sv
module drb_prio_sel #(
  parameter int unsigned NUM_ROWS = drb_pkg::DEF_ROWS,
  parameter int unsigned BND_W    = drb_pkg::DEF_BND_W
) (
  input  logic [NUM_ROWS-1:0]       match,
  input  logic [NUM_ROWS*BND_W-1:0] lo_flat,
  output logic [NUM_ROWS-1:0]       sel,
  output logic                      any,
  output logic [BND_W-1:0]          base_gran
);
  always_comb begin
    sel       = match & (~match + NUM_ROWS'(1));
    any       = |match;
    base_gran = '0;
    for (int i = 0; i < NUM_ROWS; i++) begin
      if (sel[i]) base_gran = base_gran | lo_flat[i*BND_W +: BND_W];
    end
  end
endmodule

// File: rtl/drb_decoder.sv
module drb_decoder #(
  parameter int unsigned NUM_ROWS = drb_pkg::DEF_ROWS,
  parameter int unsigned BND_W    = drb_pkg::DEF_BND_W,
  parameter int unsigned ADDR_W   = drb_pkg::DEF_ADDR_W,
  parameter int unsigned GRAN_LSB = drb_pkg::DEF_GRAN_LSB,
  localparam int unsigned IDX_W   = $clog2(NUM_ROWS),
  localparam int unsigned PAD_W   = ADDR_W - BND_W - GRAN_LSB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_row,
  input  logic [BND_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_ROWS-1:0] row_sel,
  output logic                hit,
  output logic [ADDR_W-1:0]   row_base,
  output logic [NUM_ROWS-1:0] row_pop,
  output logic [BND_W-1:0]    top_mem
);
  logic [NUM_ROWS*BND_W-1:0] bnd_flat;
  logic [NUM_ROWS*BND_W-1:0] lo_flat;
  logic [NUM_ROWS-1:0]       match;
  logic [NUM_ROWS-1:0]       sel_raw;
  logic                      any_match;
  logic [BND_W-1:0]          base_gran;
  logic                      below_top;

  drb_regfile #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_data(wr_data), .bnd_flat(bnd_flat)
  );

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    if (i == 0) begin : g_first
      assign lo_flat[0 +: BND_W] = '0;
    end else begin : g_next
      assign lo_flat[i*BND_W +: BND_W] = bnd_flat[(i-1)*BND_W +: BND_W];
    end

    drb_row_cmp #(.BND_W(BND_W), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_cmp (
      .lo_gran(lo_flat[i*BND_W +: BND_W]),
      .hi_gran(bnd_flat[i*BND_W +: BND_W]),
      .addr(addr),
      .populated(row_pop[i]),
      .match(match[i])
    );
  end

  drb_prio_sel #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W)) u_sel (
    .match(match), .lo_flat(lo_flat), .sel(sel_raw),
    .any(any_match), .base_gran(base_gran)
  );

  always_comb begin
    top_mem   = bnd_flat[(NUM_ROWS-1)*BND_W +: BND_W];
    below_top = addr < {{PAD_W{1'b0}}, top_mem, {GRAN_LSB{1'b0}}};
    hit       = any_match && below_top;
    row_sel   = hit ? sel_raw : '0;
    row_base  = hit ? {{PAD_W{1'b0}}, base_gran, {GRAN_LSB{1'b0}}} : '0;
  end
endmodule

// File: rtl/drb_decoder_chk.sv
module drb_decoder_chk #(
  parameter int unsigned NUM_ROWS = drb_pkg::DEF_ROWS,
  parameter int unsigned BND_W    = drb_pkg::DEF_BND_W,
  parameter int unsigned ADDR_W   = drb_pkg::DEF_ADDR_W,
  parameter int unsigned GRAN_LSB = drb_pkg::DEF_GRAN_LSB,
  localparam int unsigned IDX_W   = $clog2(NUM_ROWS),
  localparam int unsigned PAD_W   = ADDR_W - BND_W - GRAN_LSB
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [IDX_W-1:0]    wr_row,
  input logic [BND_W-1:0]    wr_data,
  input logic [ADDR_W-1:0]   addr,
  input logic [NUM_ROWS-1:0] row_sel,
  input logic                hit,
  input logic [ADDR_W-1:0]   row_base,
  input logic [NUM_ROWS-1:0] row_pop,
  input logic [BND_W-1:0]    top_mem
);
  logic [ADDR_W-1:0] top_byte;
  assign top_byte = {{PAD_W{1'b0}}, top_mem, {GRAN_LSB{1'b0}}};

  p_write_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_row == IDX_W'(NUM_ROWS-1)) |=> (top_mem == $past(wr_data)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(top_mem) && $stable(row_pop)));

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($countones(row_sel) == 1));

  p_miss_nosel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (row_sel == '0));

  p_sel_populated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_sel & ~row_pop) == '0);

  p_above_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= top_byte) |-> !hit);

  p_base_below_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (row_base <= addr));

  p_base_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (row_base == '0));
endmodule

bind drb_decoder drb_decoder_chk #(
  .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
  .addr(addr), .row_sel(row_sel), .hit(hit), .row_base(row_base),
  .row_pop(row_pop), .top_mem(top_mem)
);

// File: tb/sim_drb_decoder.sv
`timescale 1ns/1ps
module sim_drb_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_row;
  logic [7:0]  wr_data;
  logic [31:0] addr;
  logic [7:0]  row_sel;
  logic        hit;
  logic [31:0] row_base;
  logic [7:0]  row_pop;
  logic [7:0]  top_mem;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic [7:0] bnd_m [8];

  drb_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .addr(addr), .row_sel(row_sel), .hit(hit), .row_base(row_base),
    .row_pop(row_pop), .top_mem(top_mem)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  function automatic logic [7:0] pop_model();
    logic [7:0] p;
    logic [7:0] prev;
    prev = 8'd0;
    for (int i = 0; i < 8; i++) begin
      p[i] = bnd_m[i] > prev;
      prev = bnd_m[i];
    end
    return p;
  endfunction

  task automatic probe(input logic [31:0] a, input string req);
    logic [7:0]  es;
    logic        eh;
    logic [31:0] eb;
    logic [7:0]  prev;
    es = '0; eh = 1'b0; eb = '0; prev = 8'd0;
    for (int i = 0; i < 8; i++) begin
      if (!eh && bnd_m[i] > prev && a >= {1'b0, prev, 23'd0} && a < {1'b0, bnd_m[i], 23'd0}) begin
        eh = 1'b1; es[i] = 1'b1; eb = {1'b0, prev, 23'd0};
      end
      prev = bnd_m[i];
    end
    if (a >= {1'b0, bnd_m[7], 23'd0}) begin
      es = '0; eh = 1'b0; eb = '0;
    end
    @(negedge clk);
    addr = a;
    #2;
    chk({req, " row_sel"}, 32'(row_sel), 32'(es));
    chk({req, " hit"},     32'(hit),     32'(eh));
    chk({req, " row_base"}, row_base,    eb);
  endtask

  task automatic wr(input int r, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_row = 3'(r); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    bnd_m[r] = v;
  endtask

  task automatic load(input logic [7:0] v0, v1, v2, v3, v4, v5, v6, v7);
    wr(0, v0); wr(1, v1); wr(2, v2); wr(3, v3);
    wr(4, v4); wr(5, v5); wr(6, v6); wr(7, v7);
    #2;
    chk("R3 row_pop", 32'(row_pop), 32'(pop_model()));
    chk("R9 top_mem", 32'(top_mem), 32'(bnd_m[7]));
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) bnd_m[i] = 8'h01;
    #2;
    chk("R1 row_pop", 32'(row_pop), 32'h01);
    chk("R1 top_mem", 32'(top_mem), 32'h01);
    probe(32'h0000_0000, "R1");
    probe(32'h007F_FFFF, "R1");
    probe(32'h0080_0000, "R6");
  endtask

  task automatic t_write_timing();
    @(negedge clk);
    wr_en = 1'b1; wr_row = 3'd7; wr_data = 8'h40;
    #2;
    chk("R2 before edge", 32'(top_mem), 32'h01);
    @(negedge clk);
    wr_en = 1'b0;
    bnd_m[7] = 8'h40;
    #2;
    chk("R2 after edge", 32'(top_mem), 32'h40);
    chk("R3 gap rows", 32'(row_pop), 32'h81);
    @(negedge clk);
    wr_row = 3'd0; wr_data = 8'h33;
    @(negedge clk);
    #2;
    chk("R2 no strobe", 32'(row_pop), 32'h81);
    probe(32'h0080_0000, "R2 no strobe");
  endtask

  task automatic t_ordered();
    load(8'd2, 8'd2, 8'd6, 8'd6, 8'd8, 8'd10, 8'd10, 8'd16);
    chk("R3 ordered pop", 32'(row_pop), 32'hB5);
    for (int g = 0; g < 20; g++) probe({1'b0, 8'(g), 23'h12345}, "R4 R5 sweep");
    probe(32'h00FF_FFFF, "R10 last byte row0");
    probe(32'h0100_0000, "R10 R5 first byte row2");
    probe(32'h02FF_FFFF, "R10 last byte row2");
    probe(32'h0300_0000, "R10 R5 first byte row4");
    probe(32'h07FF_FFFF, "R10 last byte row7");
    probe(32'h0800_0000, "R6 at top");
    probe(32'h8000_0000, "R6 bit31");
  endtask

  task automatic t_overlap();
    load(8'd4, 8'd2, 8'd6, 8'd20, 8'd20, 8'd20, 8'd20, 8'd20);
    probe({1'b0, 8'd2, 23'd0}, "R7 overlap low row");
    probe({1'b0, 8'd3, 23'h7FFFFF}, "R7 overlap edge");
    probe({1'b0, 8'd4, 23'd0}, "R7 upper row");
    probe({1'b0, 8'd7, 23'd0}, "R8 base row3");
    for (int g = 0; g < 24; g++) probe({1'b0, 8'(g), 23'd0}, "R5 R7 sweep");
  endtask

  task automatic t_top_limit();
    load(8'd30, 8'd30, 8'd30, 8'd30, 8'd30, 8'd30, 8'd30, 8'd10);
    probe({1'b0, 8'd5, 23'd0}, "R4 below top");
    probe({1'b0, 8'd10, 23'd0}, "R6 at top over row0");
    probe({1'b0, 8'd15, 23'd0}, "R6 above top");
    probe(32'hFFFF_FFFF, "R6 max addr");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_row = '0; wr_data = '0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_timing();
    t_ordered();
    t_overlap();
    t_top_limit();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule